// File: doc/BRIEF.md
# Pipelined Symmetric Nine-Tap Pixel Filter

This block filters a stream of 8-bit pixels at one pixel per clock. Each output is a weighted sum over a window of nine consecutive input pixels centred on the target pixel. The weights are mirrored about the centre, so five programmable coefficients are enough. Every pair of pixels that lie the same distance from the centre is added before it is multiplied, which cuts the work to five multiplies per pixel.

The block does not sum a window in one place. Partial sums move through a chain of five registers. On every accepted pixel, the register at stage k takes the partial sum from stage k-1 and adds coefficient k times the sum of the new pixel and the pixel 2k positions back. While one output leaves the end of the chain, the partial sums for the next four outputs are still on their way down it. The last register then holds a finished result four pixel positions behind the input. That result is rounded, shifted back to integer pixel scale and clamped to 0..255.

A low input strobe freezes the whole pipeline, and the output strobe marks each new result. Coefficients are taken directly from the ports. They are meant to be set while the block is in reset or while no result is in flight.

Top module: `symfir_pipe`

## Requirements
- R1: Reset is synchronous and active high. On the cycle after a clock edge with `rst` high, `out_valid` is 0 and `out_pix` is 0.
- R2: Number the pixels accepted since reset from 0, where a pixel is accepted at a rising edge with `in_valid` high. When pixel n is accepted with n >= 4, `out_valid` is 1 during the following cycle, and `out_pix` holds the filtered result for centre pixel n-4.
- R3: A pixel position before the first accepted pixel after reset counts as value 0 in every window.
- R4: A rising edge with `in_valid` low accepts nothing. In the following cycle `out_valid` is 0 and `out_pix` keeps its previous value.
- R5: The first four accepted pixels after reset produce no `out_valid` pulse.
- R6: For centre m, let S = c0*x[m] + sum over k=1..4 of ck*(x[m+k] + x[m-k]). Before clamping, the result is floor((S + 128) / 256), which rounds a half up.
- R7: A rounded result below 0 is output as 0. A rounded result above 255 is output as 255.
- R8: `coef_flat` bits [10k+9:10k] hold coefficient ck for k = 0..4. Each coefficient is 10-bit two's complement with 8 fractional bits, and ck weights the pair of pixels at distance k from the centre. Coefficients must stay constant while any result that depends on them is still being computed.
- R9: A run of N pixels accepted on consecutive edges directly after reset yields N-4 results, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel strobe; when low the pipeline holds |
| in_pix | input | 8 | Input pixel, unsigned |
| coef_flat | input | 50 | Five packed signed coefficients, c0 in the low bits |
| out_valid | output | 1 | High for one cycle per new result |
| out_pix | output | 8 | Filtered, rounded and clamped pixel |

## Verification
Three things can land in the same cycle: a finished result reaches the output, rounding and clamping act on it, and the input strobe drops so the chain must freeze. The random cases drop `in_valid` at random cycles, so stalls often begin at the moment a result is due. Each stall cycle is judged by checking that `out_valid` is low and that `out_pix` has not changed. Every delivered result is compared with a window sum that the bench computes from all pixels driven since reset, with positions before the first pixel taken as zero. The directed cases drive sums that end exactly on a half LSB, sums far above the top of the range and sums far below zero.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    localparam int PIX_W_DEF  = 8;
    localparam int COEF_W_DEF = 10;
    localparam int FRAC_W_DEF = 8;
    localparam int HALF_DEF   = 4;

    // width of one pre-added product: signed coefficient times (pair + sign bit)
    function automatic int prod_width(input int pix_w, input int coef_w);
        return coef_w + pix_w + 2;
    endfunction

    // accumulator width: product plus growth over HALF+1 terms
    function automatic int acc_width(input int pix_w, input int coef_w, input int half);
        return prod_width(pix_w, coef_w) + $clog2(half + 1);
    endfunction

endpackage

// File: rtl/symfir_hist.sv
module symfir_hist #(
    parameter int PIX_W = 8,
    parameter int HALF  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] even_o [1:HALF]
);
    localparam int DEPTH = 2 * HALF;

    logic [PIX_W-1:0] sr [1:DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 1; j <= DEPTH; j++) sr[j] <= '0;
        end else if (adv) begin
            sr[1] <= pix_i;
            for (int j = 2; j <= DEPTH; j++) sr[j] <= sr[j-1];
        end
    end

    for (genvar k = 1; k <= HALF; k++) begin : g_tap
        assign even_o[k] = sr[2*k];
    end

    // R4: a stalled cycle leaves the history untouched
    assert_hist_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> (sr[DEPTH] == $past(sr[DEPTH]) && sr[1] == $past(sr[1])));

endmodule

// File: rtl/symfir_stage.sv
module symfir_stage #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 10,
    parameter int ACC_W  = 23
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic [PIX_W-1:0]         pix_new,
    input  logic [PIX_W-1:0]         pix_old,
    input  logic signed [COEF_W-1:0] coef_i,
    input  logic signed [ACC_W-1:0]  acc_i,
    output logic signed [ACC_W-1:0]  acc_o
);
    localparam int PW = COEF_W + PIX_W + 2;

    logic [PIX_W:0]          pair;
    logic signed [PIX_W+1:0] pair_s;
    logic signed [PW-1:0]    prod;

    always_comb begin
        pair   = {1'b0, pix_new} + {1'b0, pix_old};
        pair_s = signed'({1'b0, pair});
        prod   = PW'(coef_i) * PW'(pair_s);
    end

    always_ff @(posedge clk) begin
        if (rst)      acc_o <= '0;
        else if (adv) acc_o <= acc_i + ACC_W'(prod);
    end

    // R4: partial sum frozen while the input strobe is low
    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(acc_o));

endmodule

// File: rtl/symfir_outfmt.sv
module symfir_outfmt #(
    parameter int ACC_W  = 23,
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic signed [ACC_W-1:0] acc_i,
    output logic [PIX_W-1:0]        pix_o
);
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] TOP      = ACC_W'(2**PIX_W - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM  = -HALF_LSB;
    localparam logic signed [ACC_W-1:0] SAT_LIM  = (TOP <<< FRAC_W) + HALF_LSB;

    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] sh;

    always_comb begin
        rnd = acc_i + HALF_LSB;
        sh  = rnd >>> FRAC_W;
        if (sh[ACC_W-1])  pix_o = '0;
        else if (sh > TOP) pix_o = '1;
        else               pix_o = sh[PIX_W-1:0];
    end

    always_comb begin
        if (acc_i < NEG_LIM)
            assert_clamp_low_R7: assert (pix_o == '0);
        if (acc_i >= SAT_LIM)
            assert_clamp_high_R7: assert (pix_o == '1);
    end

endmodule

// File: rtl/symfir_pipe.sv
module symfir_pipe
    import symfir_pkg::*;
#(
    parameter int PIX_W  = PIX_W_DEF,
    parameter int COEF_W = COEF_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int HALF   = HALF_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [PIX_W-1:0]           in_pix,
    input  logic [(HALF+1)*COEF_W-1:0] coef_flat,
    output logic                       out_valid,
    output logic [PIX_W-1:0]           out_pix
);
    localparam int ACC_W = acc_width(PIX_W, COEF_W, HALF);
    localparam int FW    = $clog2(HALF + 1);

    logic [PIX_W-1:0]        tap [1:HALF];
    logic signed [ACC_W-1:0] acc [HALF+1];
    logic [FW-1:0]           fill;
    logic                    primed;

    symfir_hist #(.PIX_W(PIX_W), .HALF(HALF)) u_hist (
        .clk(clk), .rst(rst), .adv(in_valid), .pix_i(in_pix), .even_o(tap)
    );

    for (genvar k = 0; k <= HALF; k++) begin : g_stage
        logic [PIX_W-1:0]        old_pix;
        logic signed [ACC_W-1:0] acc_in;
        if (k == 0) begin : g_head
            assign old_pix = '0;
            assign acc_in  = '0;
        end else begin : g_body
            assign old_pix = tap[k];
            assign acc_in  = acc[k-1];
        end
        symfir_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_stage (
            .clk(clk), .rst(rst), .adv(in_valid),
            .pix_new(in_pix), .pix_old(old_pix),
            .coef_i($signed(coef_flat[k*COEF_W +: COEF_W])),
            .acc_i(acc_in), .acc_o(acc[k])
        );
    end

    symfir_outfmt #(.ACC_W(ACC_W), .PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_fmt (
        .acc_i(acc[HALF]), .pix_o(out_pix)
    );

    assign primed = (fill == FW'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill      <= '0;
            out_valid <= 1'b0;
        end else begin
            if (in_valid && !primed) fill <= fill + 1'b1;
            out_valid <= in_valid && primed;
        end
    end

    // R4: a stall produces no result and holds the output
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_pix)));

    // R2: every result is the consequence of an accept one edge earlier
    assert_result_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5: no result while the window is still filling
    assert_no_early_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fill < FW'(HALF)) |=> !out_valid);

endmodule

// File: tb/symfir_pipe_bench.sv
`timescale 1ns/1ps
module symfir_pipe_bench;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    in_pix = '0;
    logic [5*CW-1:0] coef_flat = '0;
    logic          out_valid;
    logic [7:0]    out_pix;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_q[$];
    int hist[$];
    int c[5];
    int n_out = 0;
    int last_out = 0;
    int held = 0;
    int e;
    logic s_iv = 1'b0;
    logic s_rst = 1'b1;
    string tag = "R1";

    always #2 clk = ~clk;

    symfir_pipe u_symfir_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .coef_flat(coef_flat), .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    // independent window model: R3 zero before start, R6 rounding, R7 clamp
    function automatic int model(input int m);
        int sum = 0;
        int r;
        for (int j = -4; j <= 4; j++) begin
            int idx = m + j;
            int v = (idx >= 0 && idx < hist.size()) ? hist[idx] : 0;
            int k = (j < 0) ? -j : j;
            sum += c[k] * v;
        end
        r = (sum + 128) >>> 8;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic set_coefs(input int a, input int b, input int d, input int f, input int g);
        c[0] = a; c[1] = b; c[2] = d; c[3] = f; c[4] = g;
        for (int k = 0; k < 5; k++) coef_flat[k*CW +: CW] = c[k][CW-1:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        check(exp_q.size() == 0, {tag, " R2 undelivered results"}, exp_q.size(), 0);
        exp_q.delete();
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_pix == 8'd0, "R1 out_pix in reset", int'(out_pix), 0);
        hist.delete();
        rst = 1'b0;
    endtask

    task automatic push(input int p);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix = p[7:0];
        hist.push_back(p);
        if (hist.size() >= 5) exp_q.push_back(model(hist.size() - 5));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        s_iv  <= in_valid;
        s_rst <= rst;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!s_rst) begin
            if (out_valid) begin
                if (!s_iv) check(1'b0, "R4 result after stall edge", 1, 0);
                if (exp_q.size() == 0) check(1'b0, {tag, " R5 unexpected result"}, int'(out_pix), -1);
                else begin
                    e = exp_q.pop_front();
                    check(int'(out_pix) == e, {tag, " R2 result"}, int'(out_pix), e);
                end
                n_out++;
                last_out = int'(out_pix);
            end else if (!s_iv) begin
                check(int'(out_pix) == held, "R4 hold on stall", int'(out_pix), held);
            end
        end
        held = int'(out_pix);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual %0d expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        set_coefs(256, 0, 0, 0, 0);
        tag = "R1";
        do_reset();

        // R2 identity with periodic stalls (R4)
        tag = "R2 identity";
        for (int i = 0; i < 30; i++) begin
            push(i * 7 + 3);
            if (i % 5 == 4) idle(1);
        end
        idle(3);

        // R5 warm-up produces nothing
        tag = "R5 warmup";
        do_reset();
        n0 = n_out;
        for (int i = 0; i < 4; i++) push(100 + i);
        idle(3);
        check(n_out == n0, "R5 no result in first four", n_out - n0, 0);
        hist.delete();

        // R3 zero history, outermost pair only
        set_coefs(0, 0, 0, 0, 256);
        tag = "R3 zero history";
        do_reset();
        for (int i = 1; i <= 5; i++) push(i * 10);
        idle(2);
        check(last_out == 50, "R3 centre0 sees zero on the left", last_out, 50);
        push(60);
        idle(2);
        check(last_out == 60, "R3 centre1 sees zero on the left", last_out, 60);

        // R6 rounding half up with c0 = 0.5
        set_coefs(128, 0, 0, 0, 0);
        tag = "R6 rounding";
        do_reset();
        push(3); push(5); push(7); push(1);
        push(0); push(0); push(0); push(0);
        idle(2);
        check(last_out == 1, "R6 half of 1 rounds up", last_out, 1);

        // R7 saturation high and low
        set_coefs(511, 511, 511, 511, 511);
        tag = "R7 clamp high";
        do_reset();
        for (int i = 0; i < 9; i++) push(255);
        idle(2);
        check(last_out == 255, "R7 clamp to 255", last_out, 255);
        set_coefs(-512, -512, -512, -512, -512);
        tag = "R7 clamp low";
        do_reset();
        for (int i = 0; i < 9; i++) push(200);
        idle(2);
        check(last_out == 0, "R7 clamp to 0", last_out, 0);

        // R8 single pair coefficient slots
        set_coefs(0, 0, 256, 0, 0);
        tag = "R8 pair k2";
        do_reset();
        for (int i = 0; i < 20; i++) push(int'($urandom_range(0, 120)));
        idle(3);
        set_coefs(0, 0, 0, 128, 0);
        tag = "R8 pair k3";
        do_reset();
        for (int i = 0; i < 20; i++) push(int'($urandom_range(0, 255)));
        idle(3);

        // R9 back-to-back throughput
        set_coefs(40, 30, 20, 10, 5);
        tag = "R9 throughput";
        do_reset();
        n0 = n_out;
        for (int i = 0; i < 40; i++) push(int'($urandom_range(0, 255)));
        idle(2);
        check(n_out - n0 == 36, "R9 one result per accept", n_out - n0, 36);

        // random coefficients, pixels and stalls
        for (int r = 0; r < 6; r++) begin
            set_coefs(int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 400)) - 200,
                      int'($urandom_range(0, 400)) - 200, int'($urandom_range(0, 200)) - 100,
                      int'($urandom_range(0, 200)) - 100);
            tag = "R2 random";
            do_reset();
            for (int i = 0; i < 150; i++) begin
                push(int'($urandom_range(0, 255)));
                if ($urandom_range(0, 9) < 3) idle(int'($urandom_range(1, 3)));
            end
            idle(3);
        end
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule